// File: doc/BRIEF.md
# Indirect Routing-Table Register Window

This block is the software-facing register front end of an interrupt routing controller. It occupies two bus locations. The first holds an 8-bit select value. The second is a 32-bit data window that reaches whichever internal register the select value names: a read-only version word, an identifier register, a read-only arbitration register, or one half of a 64-bit routing entry. There is one routing entry per interrupt pin.

The block holds the routing table and, for each pin, a mask bit and a remote-pending flag. It drives every entry's decoded fields as flat output vectors for the delivery logic. A separate delivery unit sets a pin's remote-pending flag through `rp_set`. Software clears that flag by writing the low half of the entry. Whenever a write flips an entry's mask bit, the block emits a one-cycle event that carries the pin number. Reads are combinational from the current state. Writes take effect on the clock edge that samples `wr_en`.

Top module: `irq_window_top`

## Requirements
- R1: A write to the select location (`addr_win`=0) keeps only `wdata[7:0]`. A read of the select location returns that byte in bits 7:0 with zeros above.
- R2: With select 0x01 the window reads `NUM_PINS-1` in bits 23:16 and `VERSION_CODE` in bits 7:0, with all other bits zero. Writes to it change no state.
- R3: Select 0x00 (identifier) and select 0x02 (arbitration) both read the 4-bit identifier in bits 27:24, with all other bits zero. A window write with select 0x00 loads `wdata[27:24]`. A window write with select 0x02 is ignored.
- R4: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. Each half reads back as written.
- R5: The entry layout is vector in bits 7:0, delivery mode in 10:8, destination mode in 11, remote-pending in 14, trigger mode in 15 (1 = level), mask in 16 and destination in 63:56. Each pin's fields appear on the `out_*` ports one cycle after the write.
- R6: A window read at a select whose entry index is at or beyond `NUM_PINS` returns 0xFFFFFFFF. A window write there changes no entry.
- R7: `rp_set[i]` sets pin i's remote-pending flag, which reads back in bit 14 of the low half. A write of the low half clears the flag. Writes cannot set bit 14. If `rp_set[i]` and a low-half write to entry i fall in the same cycle, the flag ends up set.
- R8: After reset every mask bit is 1, every other entry bit is 0, every remote-pending flag is 0, and the select value and the identifier are 0.
- R9: A low-half write that changes an entry's mask bit raises `mask_evt` for exactly the following cycle, with `mask_evt_pin` set to the entry index. A write that leaves the mask unchanged raises no event.
- R10: Select values 0x03 to 0x0F read as zero through the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed location |
| addr_win | input | 1 | 0 = select location, 1 = data window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed location (combinational) |
| rp_set | input | NUM_PINS | Per-pin set request for remote-pending |
| out_vector | output | NUM_PINS*8 | Vector field of each entry |
| out_dlv_mode | output | NUM_PINS*3 | Delivery-mode field of each entry |
| out_dst_mode | output | NUM_PINS | Destination-mode bit of each entry |
| out_level | output | NUM_PINS | Trigger-mode bit of each entry (1 = level) |
| out_mask | output | NUM_PINS | Mask bit of each entry |
| out_remote | output | NUM_PINS | Remote-pending flag of each entry |
| out_dest | output | NUM_PINS*8 | Destination field of each entry |
| mask_evt | output | 1 | One-cycle pulse after a mask bit flips |
| mask_evt_pin | output | 7 | Entry index that goes with `mask_evt` |

## Verification
Two functions can land on the same edge: a software write to an entry's low half, which clears remote-pending, and a set request from the delivery side for that same pin. The bench drives `rp_set` in the same cycle as a low-half write to the same entry and expects the flag to stay set. This is judged both on `out_remote` and on bit 14 of the window readback. The bench also checks the mirror case, where a high-half write in the presence of a pending flag leaves the flag alone.

// File: rtl/irq_window_pkg.sv
package irq_window_pkg;

  localparam logic [7:0] SEL_IDENT = 8'h00;
  localparam logic [7:0] SEL_VERS  = 8'h01;
  localparam logic [7:0] SEL_ARBIT = 8'h02;
  localparam logic [7:0] SEL_TABLE = 8'h10;

  localparam int IDX_W = 7;

  // routing-entry low-half bit positions
  localparam int B_DSTMODE = 11;
  localparam int B_REMOTE  = 14;
  localparam int B_LEVEL   = 15;
  localparam int B_MASK    = 16;

  typedef enum logic [2:0] {
    ACC_IDENT,
    ACC_VERS,
    ACC_ARBIT,
    ACC_TABLE,
    ACC_OOR,
    ACC_NONE
  } acc_kind_e;

  // entry number reached by a table select value
  function automatic logic [IDX_W-1:0] entry_of(input logic [7:0] sel);
    logic [7:0] d;
    d = sel - SEL_TABLE;
    return d[7:1];
  endfunction

  function automatic logic [31:0] version_word(input int npins, input logic [7:0] code);
    logic [7:0] top;
    top = 8'(npins - 1);
    return {8'h00, top, 8'h00, code};
  endfunction

  function automatic logic [31:0] ident_word(input logic [3:0] id);
    return {4'h0, id, 24'h000000};
  endfunction

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
  import irq_window_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic [7:0]       sel,
  output acc_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi_half
);

  logic [7:0] delta;

  always_comb begin
    delta   = sel - SEL_TABLE;
    idx     = entry_of(sel);
    hi_half = delta[0];
    if (sel == SEL_IDENT)      kind = ACC_IDENT;
    else if (sel == SEL_VERS)  kind = ACC_VERS;
    else if (sel == SEL_ARBIT) kind = ACC_ARBIT;
    else if (sel < SEL_TABLE)  kind = ACC_NONE;
    else if (32'(idx) < NUM_PINS) kind = ACC_TABLE;
    else                       kind = ACC_OOR;
  end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_window_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [IDX_W-1:0]      idx,
  input  logic [31:0]           wdata,
  input  logic [NUM_PINS-1:0]   rp_set,
  output logic [31:0]           rd_lo,
  output logic [31:0]           rd_hi,
  output logic [NUM_PINS*8-1:0] out_vector,
  output logic [NUM_PINS*3-1:0] out_dlv_mode,
  output logic [NUM_PINS-1:0]   out_dst_mode,
  output logic [NUM_PINS-1:0]   out_level,
  output logic [NUM_PINS-1:0]   out_mask,
  output logic [NUM_PINS-1:0]   out_remote,
  output logic [NUM_PINS*8-1:0] out_dest,
  output logic                  mask_evt,
  output logic [IDX_W-1:0]      mask_evt_pin
);

  localparam logic [31:0] LO_RESET = 32'(1) << B_MASK;
  localparam logic [31:0] RO_BITS  = 32'(1) << B_REMOTE;

  logic [31:0]         lo_q [NUM_PINS];
  logic [31:0]         hi_q [NUM_PINS];
  logic [NUM_PINS-1:0] remote_q;
  logic                cur_mask;
  logic                mask_flip;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic hit;
    assign hit = (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= '0;
      end else begin
        if (wr_lo && hit) lo_q[i] <= wdata & ~RO_BITS;
        if (wr_hi && hit) hi_q[i] <= wdata;
      end
    end

    // delivery-side set outranks the software clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remote_q[i] <= 1'b0;
      else if (rp_set[i])        remote_q[i] <= 1'b1;
      else if (wr_lo && hit)     remote_q[i] <= 1'b0;
    end

    assign out_vector[i*8 +: 8]   = lo_q[i][7:0];
    assign out_dlv_mode[i*3 +: 3] = lo_q[i][10:8];
    assign out_dst_mode[i]        = lo_q[i][B_DSTMODE];
    assign out_level[i]           = lo_q[i][B_LEVEL];
    assign out_mask[i]            = lo_q[i][B_MASK];
    assign out_remote[i]          = remote_q[i];
    assign out_dest[i*8 +: 8]     = hi_q[i][31:24];
  end

  always_comb begin
    rd_lo    = '0;
    rd_hi    = '0;
    cur_mask = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_lo    = lo_q[i] | (remote_q[i] ? RO_BITS : 32'h0);
        rd_hi    = hi_q[i];
        cur_mask = lo_q[i][B_MASK];
      end
    end
  end

  assign mask_flip = wr_lo && (wdata[B_MASK] != cur_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_evt     <= 1'b0;
      mask_evt_pin <= '0;
    end else begin
      mask_evt     <= mask_flip;
      mask_evt_pin <= idx;
    end
  end

endmodule

// File: rtl/irq_window_top.sv
module irq_window_top
  import irq_window_pkg::*;
#(
  parameter int          NUM_PINS     = 24,
  parameter logic [7:0]  VERSION_CODE = 8'h11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  addr_win,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  input  logic [NUM_PINS-1:0]   rp_set,
  output logic [NUM_PINS*8-1:0] out_vector,
  output logic [NUM_PINS*3-1:0] out_dlv_mode,
  output logic [NUM_PINS-1:0]   out_dst_mode,
  output logic [NUM_PINS-1:0]   out_level,
  output logic [NUM_PINS-1:0]   out_mask,
  output logic [NUM_PINS-1:0]   out_remote,
  output logic [NUM_PINS*8-1:0] out_dest,
  output logic                  mask_evt,
  output logic [6:0]            mask_evt_pin
);

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  acc_kind_e        kind;
  logic [IDX_W-1:0] idx;
  logic             hi_half;
  logic             wr_sel;
  logic             wr_win;
  logic             wr_lo;
  logic             wr_hi;
  logic [31:0]      tbl_lo;
  logic [31:0]      tbl_hi;

  assign wr_sel = wr_en && !addr_win;
  assign wr_win = wr_en && addr_win;
  assign wr_lo  = wr_win && (kind == ACC_TABLE) && !hi_half;
  assign wr_hi  = wr_win && (kind == ACC_TABLE) && hi_half;

  irq_win_decode #(.NUM_PINS(NUM_PINS)) dec_i (
    .sel     (sel_q),
    .kind    (kind),
    .idx     (idx),
    .hi_half (hi_half)
  );

  irq_route_table #(.NUM_PINS(NUM_PINS)) tbl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_lo        (wr_lo),
    .wr_hi        (wr_hi),
    .idx          (idx),
    .wdata        (wdata),
    .rp_set       (rp_set),
    .rd_lo        (tbl_lo),
    .rd_hi        (tbl_hi),
    .out_vector   (out_vector),
    .out_dlv_mode (out_dlv_mode),
    .out_dst_mode (out_dst_mode),
    .out_level    (out_level),
    .out_mask     (out_mask),
    .out_remote   (out_remote),
    .out_dest     (out_dest),
    .mask_evt     (mask_evt),
    .mask_evt_pin (mask_evt_pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata[7:0];
      if (wr_win && kind == ACC_IDENT) id_q <= wdata[27:24];
    end
  end

  always_comb begin
    if (!addr_win) begin
      rdata = {24'h000000, sel_q};
    end else begin
      unique case (kind)
        ACC_IDENT, ACC_ARBIT: rdata = ident_word(id_q);
        ACC_VERS:             rdata = version_word(NUM_PINS, VERSION_CODE);
        ACC_TABLE:            rdata = hi_half ? tbl_hi : tbl_lo;
        ACC_OOR:              rdata = '1;
        default:              rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_window_chk.sv
module irq_window_chk #(
  parameter int NUM_PINS = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  addr_win,
  input logic [31:0]           wdata,
  input logic [31:0]           rdata,
  input logic [NUM_PINS-1:0]   rp_set,
  input logic [NUM_PINS*8-1:0] out_vector,
  input logic [NUM_PINS*8-1:0] out_dest,
  input logic [NUM_PINS-1:0]   out_mask,
  input logic [NUM_PINS-1:0]   out_remote,
  input logic                  mask_evt,
  input logic [6:0]            mask_evt_pin,
  input logic [7:0]            sel_q,
  input logic [3:0]            id_q
);

  logic sel_oor;
  logic [7:0] sel_off;
  assign sel_off = sel_q - 8'h10;
  assign sel_oor = (sel_q >= 8'h10) && (32'(sel_off[7:1]) >= NUM_PINS);

  p_sel_low8_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_win) |=> (sel_q == $past(wdata[7:0])));

  p_vers_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_win && sel_q == 8'h01) |=>
      ($stable(id_q) && $stable(out_mask) && $stable(out_vector) && $stable(out_dest)));

  p_arb_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_win && sel_q == 8'h02) |=> $stable(id_q));

  p_oor_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_win && sel_oor) |-> (rdata == 32'hFFFF_FFFF));

  p_oor_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_win && sel_oor) |=>
      ($stable(out_mask) && $stable(out_vector) && $stable(out_dest)));

  p_evt_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> (32'(mask_evt_pin) < NUM_PINS));

  p_evt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> (out_mask != $past(out_mask)));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    p_remote_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rp_set[i] |=> out_remote[i]);

    p_remote_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr_win && sel_q == 8'(16 + 2*i) && !rp_set[i]) |=> !out_remote[i]);
  end

endmodule

bind irq_window_top irq_window_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr_win     (addr_win),
  .wdata        (wdata),
  .rdata        (rdata),
  .rp_set       (rp_set),
  .out_vector   (out_vector),
  .out_dest     (out_dest),
  .out_mask     (out_mask),
  .out_remote   (out_remote),
  .mask_evt     (mask_evt),
  .mask_evt_pin (mask_evt_pin),
  .sel_q        (sel_q),
  .id_q         (id_q)
);

// File: tb/irq_window_top_tb_top.sv
`timescale 1ns/1ps
module irq_window_top_tb_top;

  localparam int         NP  = 4;
  localparam logic [7:0] VER = 8'h21;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic            addr_win = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NP-1:0]   rp_set = '0;
  logic [NP*8-1:0] out_vector;
  logic [NP*3-1:0] out_dlv_mode;
  logic [NP-1:0]   out_dst_mode;
  logic [NP-1:0]   out_level;
  logic [NP-1:0]   out_mask;
  logic [NP-1:0]   out_remote;
  logic [NP*8-1:0] out_dest;
  logic            mask_evt;
  logic [6:0]      mask_evt_pin;

  always #2.5 clk = ~clk;

  irq_window_top #(.NUM_PINS(NP), .VERSION_CODE(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_win(addr_win),
    .wdata(wdata), .rdata(rdata), .rp_set(rp_set),
    .out_vector(out_vector), .out_dlv_mode(out_dlv_mode),
    .out_dst_mode(out_dst_mode), .out_level(out_level),
    .out_mask(out_mask), .out_remote(out_remote), .out_dest(out_dest),
    .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench-side model
  logic [31:0] m_lo [NP];
  logic [31:0] m_hi [NP];
  logic [NP-1:0] m_rem;
  logic [7:0] m_sel;
  logic [3:0] m_id;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] s);
    int k;
    if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
    if (s == 8'h01) return ((NP - 1) << 16) | 32'(VER);
    if (s < 8'h10) return 32'h0;
    k = (int'(s) - 16) / 2;
    if (k >= NP) return 32'hFFFF_FFFF;
    if (s[0]) return m_hi[k];
    return (m_lo[k] & ~32'h4000) | (m_rem[k] ? 32'h4000 : 32'h0);
  endfunction

  task automatic rd(input bit aw, output logic [31:0] v);
    addr_win = aw;
    #1;
    v = rdata;
  endtask

  // one bus cycle, model update, mask-event check (R9)
  task automatic cyc(input bit aw, input logic [31:0] wd, input logic [NP-1:0] rps);
    bit ev;
    int evp;
    int k;
    ev = 1'b0;
    evp = 0;
    if (!aw) m_sel = wd[7:0];
    else if (m_sel == 8'h00) m_id = wd[27:24];
    else if (m_sel >= 8'h10) begin
      k = (int'(m_sel) - 16) / 2;
      if (k < NP) begin
        if (m_sel[0]) m_hi[k] = wd;
        else begin
          ev = (wd[16] != m_lo[k][16]);
          evp = k;
          m_lo[k] = wd & ~32'h4000;
          m_rem[k] = 1'b0;
        end
      end
    end
    m_rem = m_rem | rps;
    @(negedge clk);
    wr_en = 1'b1; addr_win = aw; wdata = wd; rp_set = rps;
    @(negedge clk);
    wr_en = 1'b0; rp_set = '0;
    chk(mask_evt == ev, "R9 mask event", 32'(mask_evt), 32'(ev));
    if (ev) chk(mask_evt_pin == 7'(evp), "R9 event pin", 32'(mask_evt_pin), evp);
  endtask

  task automatic check_fields();
    for (int p = 0; p < NP; p++) begin
      logic [31:0] act, exp;
      act = {out_dest[p*8 +: 8], 3'b0, out_remote[p], out_mask[p], out_level[p],
             out_dst_mode[p], out_dlv_mode[p*3 +: 3], out_vector[p*8 +: 8]};
      exp = {m_hi[p][31:24], 3'b0, m_rem[p], m_lo[p][16], m_lo[p][15],
             m_lo[p][11], m_lo[p][10:8], m_lo[p][7:0]};
      chk(act == exp, "R5 decoded fields", act, exp);
    end
  endtask

  task automatic sweep_window(input string req);
    logic [31:0] v;
    for (int s = 0; s < 256; s++) begin
      cyc(1'b0, {24'hA5C3E1, 8'(s)}, '0);
      rd(1'b1, v);
      chk(v == exp_read(8'(s)), req, v, exp_read(8'(s)));
    end
  endtask

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      m_lo[p] = 32'h0001_0000; m_hi[p] = 32'h0;
    end
    m_rem = '0; m_sel = 8'h00; m_id = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd(1'b0, v);
    chk(v == 32'h0, "R8 select reset", v, 32'h0);
    chk(out_mask == {NP{1'b1}}, "R8 masks set", 32'(out_mask), 32'(~(NP'(0))));
    chk(out_remote == '0, "R8 remote clear", 32'(out_remote), 32'h0);
    chk(mask_evt == 1'b0, "R8 no event", 32'(mask_evt), 32'h0);
    check_fields();

    // R1 select byte keep
    for (int s = 0; s < 256; s += 17) begin
      cyc(1'b0, {24'hFFFF00 | 24'(s), 8'(s)}, '0);
      rd(1'b0, v);
      chk(v == 32'(s), "R1 select low byte", v, 32'(s));
    end

    // R2 R3 R4 R6 R10 full window sweep on reset contents
    sweep_window("R10/R2/R3/R6 reset sweep");

    // R3 identifier write, arbitration read-only
    cyc(1'b0, 32'h00, '0);
    cyc(1'b1, 32'h7ABC_DEF0, '0);
    rd(1'b1, v);
    chk(v == 32'h0A00_0000, "R3 ident write", v, 32'h0A00_0000);
    cyc(1'b0, 32'h02, '0);
    rd(1'b1, v);
    chk(v == 32'h0A00_0000, "R3 arbitration mirrors id", v, 32'h0A00_0000);
    cyc(1'b1, 32'h0300_0000, '0);
    rd(1'b1, v);
    chk(v == 32'h0A00_0000, "R3 arbitration write ignored", v, 32'h0A00_0000);
    // R2 version write ignored
    cyc(1'b0, 32'h01, '0);
    cyc(1'b1, 32'hFFFF_FFFF, '0);
    rd(1'b1, v);
    chk(v == exp_read(8'h01), "R2 version write ignored", v, exp_read(8'h01));
    check_fields();

    // R4 R5 R7 entry programming; low pattern tries to set bit 14
    for (int k = 0; k < NP; k++) begin
      logic [31:0] lo, hi;
      lo = 32'h0000_4000 | 32'(8'h30 + 8'(k * 17)) | (32'(k % 8) << 8)
         | (32'(k & 1) << 11) | (32'(k & 1) << 15) | 32'h00A0_0000;
      hi = {8'(8'hC0 + k), 24'h123456 ^ 24'(k)};
      cyc(1'b0, 32'(16 + 2 * k), '0);
      cyc(1'b1, lo, '0);
      cyc(1'b0, 32'(17 + 2 * k), '0);
      cyc(1'b1, hi, '0);
      // same mask again: no event (checked inside cyc)
      cyc(1'b0, 32'(16 + 2 * k), '0);
      cyc(1'b1, lo, '0);
    end
    check_fields();
    sweep_window("R4/R7 programmed sweep");

    // R7 remote-pending set, high write keeps it, low write clears it
    cyc(1'b0, 32'h12, '0);
    cyc(1'b0, 32'h12, 4'b0010);
    rd(1'b1, v);
    chk(v[14] == 1'b1, "R7 remote set readback", 32'(v[14]), 32'h1);
    cyc(1'b0, 32'h13, '0);
    cyc(1'b1, 32'h5500_0000, '0);
    chk(out_remote[1] == 1'b1, "R7 high write keeps remote", 32'(out_remote[1]), 32'h1);
    cyc(1'b0, 32'h12, '0);
    cyc(1'b1, m_lo[1], '0);
    chk(out_remote[1] == 1'b0, "R7 low write clears remote", 32'(out_remote[1]), 32'h0);
    // R7 collision: set and low write on the same edge, set wins
    cyc(1'b0, 32'h14, '0);
    cyc(1'b1, m_lo[2] | 32'h0001_0000, 4'b0100);
    chk(out_remote[2] == 1'b1, "R7 collision set wins", 32'(out_remote[2]), 32'h1);
    rd(1'b1, v);
    chk(v[14] == 1'b1, "R7 collision readback", 32'(v[14]), 32'h1);
    check_fields();

    // R6 out-of-range writes dropped
    begin
      logic [NP*8-1:0] vec0, dst0;
      logic [NP-1:0] msk0;
      vec0 = out_vector; dst0 = out_dest; msk0 = out_mask;
      cyc(1'b0, 32'(16 + 2 * NP), '0);
      cyc(1'b1, 32'h0000_0077, '0);
      cyc(1'b0, 32'(17 + 2 * NP), '0);
      cyc(1'b1, 32'h9900_0000, '0);
      chk(out_vector == vec0 && out_dest == dst0 && out_mask == msk0,
          "R6 out-of-range write dropped", 32'(out_vector), 32'(vec0));
      rd(1'b1, v);
      chk(v == 32'hFFFF_FFFF, "R6 out-of-range read", v, 32'hFFFF_FFFF);
    end

    // R9 masking each entry again, then no pulse one cycle later
    for (int k = 0; k < NP; k++) begin
      cyc(1'b0, 32'(16 + 2 * k), '0);
      cyc(1'b1, m_lo[k] ^ 32'h0001_0000, '0);
    end
    @(negedge clk);
    chk(mask_evt == 1'b0, "R9 pulse lasts one cycle", 32'(mask_evt), 32'h0);
    check_fields();
    sweep_window("R4/R6 final sweep");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule